// File: doc/BRIEF.md
# I2C Master Command Queue

This block sits between a host register port and the serial bit engine of an I2C master. The host writes 11-bit command words into one data/command register. Each word is either a byte to send or a request to read one byte, and each can ask for a STOP after it or a repeated START before it. The words wait in a transmit queue until the bit engine takes them. Bytes that the engine receives wait in a receive queue until the host reads the same register.

The host can read both queue fill levels. Two level-based interrupt outputs, one per queue, compare those levels against programmable thresholds, which lets the host refill and drain in bursts. When the engine reports an aborted transfer, both queues are emptied at once. Writing the enable register starts the controller. A separate enable-status register shows when the enable has actually taken effect, which is a fixed number of cycles later.

Both engine-facing paths are valid/ready streams. On the command stream a word moves on any cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_valid` is never raised while the controller is not enabled, and the engine may hold `cmd_ready` low for as long as it likes. On the receive stream a byte is taken on any cycle where `rxb_valid` and `rxb_ready` are both high. `rxb_ready` is low whenever the receive queue is full, and the engine must hold its byte until the queue accepts it.

Top module: `i2cm_cmd_queue`

## Requirements
- R1: A write to address 0 with bit 8 clear queues a transmit byte. Bits 7:0 appear on `cmd_byte` and `cmd_is_read` is 0. With bit 8 set, the word queues a read request and `cmd_is_read` is 1.
- R2: Bit 9 of a command word reaches the engine as `cmd_stop` and bit 10 as `cmd_restart`, alongside the byte they were written with.
- R3: A read of address 1 returns the transmit queue level and a read of address 2 returns the receive queue level. Words leave the transmit queue in the order they were written.
- R4: `irq_tx_empty` is high exactly when the transmit level is at or below the threshold held at address 3.
- R5: `irq_rx_full` is high exactly when the receive level is above the threshold held at address 4. A threshold of 0 therefore means one or more bytes are waiting.
- R6: A read of address 0 returns the oldest received byte in bits 7:0 and removes it from the receive queue.
- R7: An `eng_abort` pulse empties both queues, and both levels read 0 from the next cycle on.
- R8: Bit 0 of address 5 is the enable. Bit 0 of address 6 follows it after ENA_LAG clock cycles. `cmd_valid` is high only while that status bit is 1.
- R9: Address 7 is the status word. Bit 0 is `eng_bus_active` OR a non-empty transmit queue. Bit 2 is high when the transmit queue is empty. Bit 5 is `eng_master_active`.
- R10: A write to address 0 while the transmit queue is full is dropped. The level stays at DEPTH, the queued words are unchanged, and status bit 8 (transmit overflow) is set.
- R11: A read of address 0 while the receive queue is empty leaves the level at 0 and sets status bit 9 (receive underflow). A read of address 7 clears bits 8 and 9.
- R12: `rxb_ready` is low whenever the receive queue holds DEPTH bytes.
- R13: After reset both levels and both thresholds are 0 and the enable and both error flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 11 | Write data |
| host_rdata | output | 16 | Read data, valid in the cycle of `host_rd` |
| cmd_valid | output | 1 | A command word is offered to the engine |
| cmd_ready | input | 1 | The engine takes the offered word |
| cmd_byte | output | 8 | Byte to transmit |
| cmd_is_read | output | 1 | The word is a read request |
| cmd_stop | output | 1 | Issue a STOP after this byte |
| cmd_restart | output | 1 | Issue a repeated START before this byte |
| rxb_valid | input | 1 | The engine offers a received byte |
| rxb_ready | output | 1 | The receive queue has room |
| rxb_data | input | 8 | Received byte |
| eng_abort | input | 1 | The transfer was aborted; empty both queues |
| eng_bus_active | input | 1 | The bus is busy |
| eng_master_active | input | 1 | The master state machine is not idle |
| irq_tx_empty | output | 1 | Transmit level at or below its threshold |
| irq_rx_full | output | 1 | Receive level above its threshold |

## Verification
The embedded assertions watch, on every cycle, the rules that hold at the stream edges and at the queues. They check that command words are offered only while the controller is enabled. They check that receive ready drops at a full queue. They check that no level ever passes DEPTH. They check that an abort leaves both levels at zero and that a write into a full queue does not change its level. Only the bench scenarios can show the rest, because those checks need a history of writes and reads. That covers the decoding of command bits, the order of bytes through each queue, the threshold comparisons, the lag of the enable status, and the setting and clearing of the overflow and underflow flags.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int WR_W  = 11;
  localparam int RD_W  = 16;
  localparam int ADR_W = 3;

  localparam logic [ADR_W-1:0] A_DATA  = 3'd0;
  localparam logic [ADR_W-1:0] A_TXLVL = 3'd1;
  localparam logic [ADR_W-1:0] A_RXLVL = 3'd2;
  localparam logic [ADR_W-1:0] A_TXTH  = 3'd3;
  localparam logic [ADR_W-1:0] A_RXTH  = 3'd4;
  localparam logic [ADR_W-1:0] A_ENA   = 3'd5;
  localparam logic [ADR_W-1:0] A_ENAST = 3'd6;
  localparam logic [ADR_W-1:0] A_STAT  = 3'd7;

  localparam int ST_ACT   = 0;
  localparam int ST_TXEMP = 2;
  localparam int ST_MACT  = 5;
  localparam int ST_TXOVR = 8;
  localparam int ST_RXUND = 9;

  typedef struct packed {
    logic       restart;
    logic       stop;
    logic       rd;
    logic [7:0] data;
  } cmd_t;
endpackage

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] level,
  output logic             full,
  output logic             empty
);
  localparam logic [PTR_W-1:0] LAST  = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] DEP_C = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             do_push, do_pop;

  assign full    = (level == DEP_C);
  assign empty   = (level == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    level <= DEP_C); // R10
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0)); // R7
endmodule

// File: rtl/i2cm_ena_lag.sv
module i2cm_ena_lag #(
  parameter int ENA_LAG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ena_req,
  output logic ena_live
);
  logic [ENA_LAG-1:0] chain;

  generate
    if (ENA_LAG == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= ena_req;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[ENA_LAG-2:0], ena_req};
      end
    end
  endgenerate

  assign ena_live = chain[ENA_LAG-1];

  AST_ENA_FROM_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ena_live) |-> $past(chain[0] || ena_req)); // R8
endmodule

// File: rtl/i2cm_level_flags.sv
module i2cm_level_flags #(
  parameter int CNT_W = 4,
  parameter int ST_W  = 16
) (
  input  logic [CNT_W-1:0] tx_lvl,
  input  logic [CNT_W-1:0] rx_lvl,
  input  logic [CNT_W-1:0] tx_th,
  input  logic [CNT_W-1:0] rx_th,
  input  logic             bus_active,
  input  logic             master_active,
  input  logic             tx_over,
  input  logic             rx_under,
  output logic             irq_tx_empty,
  output logic             irq_rx_full,
  output logic [ST_W-1:0]  status
);
  import i2cm_pkg::*;

  assign irq_tx_empty = (tx_lvl <= tx_th);
  assign irq_rx_full  = (rx_lvl > rx_th);

  always_comb begin
    status           = '0;
    status[ST_ACT]   = bus_active || (tx_lvl != '0);
    status[ST_TXEMP] = (tx_lvl == '0);
    status[ST_MACT]  = master_active;
    status[ST_TXOVR] = tx_over;
    status[ST_RXUND] = rx_under;
  end
endmodule

// File: rtl/i2cm_cmd_queue.sv
module i2cm_cmd_queue #(
  parameter int DEPTH   = 8,
  parameter int ENA_LAG = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [2:0]  host_addr,
  input  logic [10:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [7:0]  cmd_byte,
  output logic        cmd_is_read,
  output logic        cmd_stop,
  output logic        cmd_restart,
  input  logic        rxb_valid,
  output logic        rxb_ready,
  input  logic [7:0]  rxb_data,
  input  logic        eng_abort,
  input  logic        eng_bus_active,
  input  logic        eng_master_active,
  output logic        irq_tx_empty,
  output logic        irq_rx_full
);
  import i2cm_pkg::*;

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] DEP_C = CNT_W'(DEPTH);

  logic [CNT_W-1:0] tx_lvl, rx_lvl, tx_th, rx_th;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic             ena_reg, ena_live, tx_over, rx_under;
  logic             host_push, host_pop, stat_rd, tx_pop, rx_push;
  cmd_t             head_cmd;
  logic [7:0]       rx_head;
  logic [RD_W-1:0]  status;

  assign host_push = host_wr && (host_addr == A_DATA);
  assign host_pop  = host_rd && (host_addr == A_DATA);
  assign stat_rd   = host_rd && (host_addr == A_STAT);
  assign tx_pop    = cmd_valid && cmd_ready;
  assign rx_push   = rxb_valid && rxb_ready;

  i2cm_fifo #(.WIDTH(WR_W), .DEPTH(DEPTH)) u_txq (
    .clk, .rst_n, .flush(eng_abort), .push(host_push), .push_data(host_wdata),
    .pop(tx_pop), .head(head_cmd), .level(tx_lvl), .full(tx_full), .empty(tx_empty)
  );

  i2cm_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_rxq (
    .clk, .rst_n, .flush(eng_abort), .push(rx_push), .push_data(rxb_data),
    .pop(host_pop), .head(rx_head), .level(rx_lvl), .full(rx_full), .empty(rx_empty)
  );

  i2cm_ena_lag #(.ENA_LAG(ENA_LAG)) u_ena (
    .clk, .rst_n, .ena_req(ena_reg), .ena_live
  );

  i2cm_level_flags #(.CNT_W(CNT_W), .ST_W(RD_W)) u_flags (
    .tx_lvl, .rx_lvl, .tx_th, .rx_th,
    .bus_active(eng_bus_active), .master_active(eng_master_active),
    .tx_over, .rx_under, .irq_tx_empty, .irq_rx_full, .status
  );

  assign cmd_valid   = ena_live && !tx_empty;
  assign cmd_byte    = head_cmd.data;
  assign cmd_is_read = head_cmd.rd;
  assign cmd_stop    = head_cmd.stop;
  assign cmd_restart = head_cmd.restart;
  assign rxb_ready   = !rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_th    <= '0;
      rx_th    <= '0;
      ena_reg  <= 1'b0;
      tx_over  <= 1'b0;
      rx_under <= 1'b0;
    end else begin
      if (host_wr && host_addr == A_TXTH) tx_th   <= host_wdata[CNT_W-1:0];
      if (host_wr && host_addr == A_RXTH) rx_th   <= host_wdata[CNT_W-1:0];
      if (host_wr && host_addr == A_ENA)  ena_reg <= host_wdata[0];
      if (host_push && tx_full)      tx_over  <= 1'b1;
      else if (stat_rd)              tx_over  <= 1'b0;
      if (host_pop && rx_empty)      rx_under <= 1'b1;
      else if (stat_rd)              rx_under <= 1'b0;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      A_DATA:  host_rdata[7:0]       = rx_empty ? 8'h00 : rx_head;
      A_TXLVL: host_rdata[CNT_W-1:0] = tx_lvl;
      A_RXLVL: host_rdata[CNT_W-1:0] = rx_lvl;
      A_TXTH:  host_rdata[CNT_W-1:0] = tx_th;
      A_RXTH:  host_rdata[CNT_W-1:0] = rx_th;
      A_ENA:   host_rdata[0]         = ena_reg;
      A_ENAST: host_rdata[0]         = ena_live;
      default: host_rdata            = status;
    endcase
  end

  AST_CMD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ena_live); // R8
  AST_RX_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_lvl == DEP_C) |-> !rxb_ready); // R12
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |=> (tx_lvl == '0 && rx_lvl == '0)); // R7
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && host_push && !tx_pop && !eng_abort) |=> (tx_lvl == DEP_C)); // R10
endmodule

// File: tb/i2cm_cmd_queue_bench.sv
module i2cm_cmd_queue_bench;
  localparam int CLK_P   = 10;
  localparam int DEPTH   = 8;
  localparam int ENA_LAG = 2;

  typedef struct packed {
    logic [10:0] word;
    logic [7:0]  e_byte;
    logic        e_rd;
    logic        e_stop;
    logic        e_rs;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{11'h05A, 8'h5A, 1'b0, 1'b0, 1'b0},
    '{11'h1FF, 8'hFF, 1'b1, 1'b0, 1'b0},
    '{11'h233, 8'h33, 1'b0, 1'b1, 1'b0},
    '{11'h4C0, 8'hC0, 1'b0, 1'b0, 1'b1},
    '{11'h701, 8'h01, 1'b1, 1'b1, 1'b1},
    '{11'h300, 8'h00, 1'b1, 1'b1, 1'b0}
  };

  logic        clk = 0, rst_n = 0;
  logic        host_wr = 0, host_rd = 0;
  logic [2:0]  host_addr = 0;
  logic [10:0] host_wdata = 0;
  logic [15:0] host_rdata;
  logic        cmd_valid, cmd_ready = 0;
  logic [7:0]  cmd_byte;
  logic        cmd_is_read, cmd_stop, cmd_restart;
  logic        rxb_valid = 0, rxb_ready;
  logic [7:0]  rxb_data = 0;
  logic        eng_abort = 0, eng_bus_active = 0, eng_master_active = 0;
  logic        irq_tx_empty, irq_rx_full;

  int errors = 0, checks = 0;
  logic [15:0] rv;

  always #(CLK_P/2) clk = ~clk;

  i2cm_cmd_queue #(.DEPTH(DEPTH), .ENA_LAG(ENA_LAG)) u_i2cm_cmd_queue (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [10:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] v);
    @(negedge clk); host_rd = 1; host_addr = a; #1 v = host_rdata;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic eng_take();
    @(negedge clk); cmd_ready = 1;
    @(negedge clk); cmd_ready = 0;
  endtask

  task automatic eng_give(logic [7:0] b);
    @(negedge clk); rxb_valid = 1; rxb_data = b;
    @(negedge clk); rxb_valid = 0;
  endtask

  initial begin
    #(CLK_P*100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R13 reset state
    rd(3'd1, rv); chk("R13 tx level", rv, 0);
    rd(3'd2, rv); chk("R13 rx level", rv, 0);
    rd(3'd3, rv); chk("R13 tx thresh", rv, 0);
    rd(3'd5, rv); chk("R13 enable", rv, 0);
    rd(3'd7, rv); chk("R13 status", rv, 16'h0004);
    chk("R13 cmd_valid", cmd_valid, 0);
    chk("R13 irq_rx_full", irq_rx_full, 0);

    // R8 enable lag
    wr(3'd5, 11'd1);
    rd(3'd6, rv); chk("R8 status lags", rv, 0);
    repeat (ENA_LAG) @(negedge clk);
    rd(3'd6, rv); chk("R8 status follows", rv, 1);

    // R1 R2 table of command words
    foreach (VECS[i]) begin
      wr(3'd0, VECS[i].word);
      chk("R8 cmd_valid", cmd_valid, 1);
      chk("R1 byte", cmd_byte, VECS[i].e_byte);
      chk("R1 read", cmd_is_read, VECS[i].e_rd);
      chk("R2 stop", cmd_stop, VECS[i].e_stop);
      chk("R2 restart", cmd_restart, VECS[i].e_rs);
      eng_take();
      rd(3'd1, rv); chk("R3 tx drained", rv, 0);
    end

    // disable, fill TX
    wr(3'd5, 11'd0);
    repeat (ENA_LAG + 1) @(negedge clk);
    chk("R8 gated off", cmd_valid, 0);
    wr(3'd3, 11'd2);
    for (int k = 0; k < DEPTH; k++) begin
      wr(3'd0, 11'(8'h10 + k));
      if (k == 1) chk("R4 at thresh", irq_tx_empty, 1);
      if (k == 2) chk("R4 above thresh", irq_tx_empty, 0);
    end
    rd(3'd1, rv); chk("R3 tx level full", rv, DEPTH);
    rd(3'd7, rv); chk("R9 status busy", rv, 16'h0001);
    eng_bus_active = 0; eng_master_active = 1;
    wr(3'd0, 11'h0EE);
    rd(3'd1, rv); chk("R10 level kept", rv, DEPTH);
    rd(3'd7, rv); chk("R10 overflow flag", rv, 16'h0121);
    rd(3'd7, rv); chk("R11 flags cleared", rv, 16'h0021);
    eng_master_active = 0;
    wr(3'd5, 11'd1);
    repeat (ENA_LAG + 1) @(negedge clk);
    for (int k = 0; k < DEPTH; k++) begin
      chk("R3 fifo order", cmd_byte, 8'h10 + k);
      eng_take();
    end
    chk("R10 dropped word absent", cmd_valid, 0);
    rd(3'd7, rv); chk("R9 status idle", rv, 16'h0004);

    // RX side
    eng_give(8'hA1); eng_give(8'hA2); eng_give(8'hA3);
    rd(3'd2, rv); chk("R3 rx level", rv, 3);
    chk("R5 thresh 0", irq_rx_full, 1);
    wr(3'd4, 11'd3);
    chk("R5 at thresh", irq_rx_full, 0);
    wr(3'd4, 11'd2);
    chk("R5 above thresh", irq_rx_full, 1);
    rd(3'd0, rv); chk("R6 first", rv, 16'h00A1);
    rd(3'd0, rv); chk("R6 second", rv, 16'h00A2);
    rd(3'd0, rv); chk("R6 third", rv, 16'h00A3);
    rd(3'd0, rv);
    rd(3'd2, rv); chk("R11 level stays 0", rv, 0);
    rd(3'd7, rv); chk("R11 underflow flag", rv, 16'h0204);
    rd(3'd7, rv); chk("R11 cleared", rv, 16'h0004);

    // R12 rx full back-pressure
    for (int k = 0; k < DEPTH; k++) eng_give(8'(k));
    chk("R12 ready low", rxb_ready, 0);

    // R7 abort
    wr(3'd5, 11'd0);
    wr(3'd0, 11'h011); wr(3'd0, 11'h022);
    @(negedge clk); eng_abort = 1;
    @(negedge clk); eng_abort = 0;
    rd(3'd1, rv); chk("R7 tx flushed", rv, 0);
    rd(3'd2, rv); chk("R7 rx flushed", rv, 0);
    chk("R12 ready back", rxb_ready, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule